// File: doc/BRIEF.md
# Serial-Clocked SAR Conversion Sequencer

This block is the digital side of an eight-input successive-approximation converter. It runs entirely from the host's serial clock, and chip select frames each exchange. While chip select is low, the block watches the serial input on rising edges. It ignores low bits until a high bit marks the start of a command. The seven bits after the start bit choose the input channel, single-ended or differential input, and the power policy.

As the channel bits arrive, the block drives the analog multiplexer selects and opens a three-clock acquisition window. The window closes when the last command bit is taken. The block then runs a 12-step binary search. It presents each trial code to the capacitor DAC and reads back a one-bit comparator decision. Each decided bit is shifted out MSB first on the falling clock edge. A one-clock busy pulse comes before the first result bit.

A new command may start 15 clocks after the previous start bit, while the low result bits are still leaving. This allows conversions back to back without raising chip select. The comparator, the DAC and the analog switches are outside this block.

Top module: `adc_serial_seq`

## Requirements
- R1: While chip select is low and no command is active, low bits on `sdi` are ignored. The first `sdi` high seen on a rising `sclk` edge is the start bit, called frame edge 1.
- R2: Command bits are taken on rising edges 2 to 8, in this order: A2, A1, A0, an ignored bit, SGL (1 = single-ended), PD1, PD0.
- R3: `acquire` is high after rising edges 5, 6 and 7 and low after rising edge 8, which begins the hold.
- R4: `busy` rises on the falling edge after rising edge 8 and falls on the next falling edge. It is never high for two consecutive falling edges.
- R5: Result bits leave on `sdo` on falling edges 9 to 20, MSB first, so a host sees them before rising edges 10 to 21. Later falling edges in the frame drive `sdo` low.
- R6: The trial code `dac_code` starts with only the MSB set. On rising edges 9 to 20, the bit under test is kept when `cmp_hi` is 1 and cleared when it is 0, and the next lower bit is set. With a monotone comparator (1 when the held input is greater than or equal to the trial), the result equals the held input code.
- R7: In single-ended mode, `pos_ch` = {A1, A0, A2}, and `neg_common` is 1.
- R8: In differential mode, `neg_common` is 0. `pos_ch` = {A1, A0, A2} and `neg_ch` = {A1, A0, ~A2}, so A2 = 0 puts the even channel of the pair on the positive side.
- R9: A high `sdi` on frame edges 9 to 15 is ignored. A start bit is accepted again from frame edge 16, so a new command can overlap the previous result.
- R10: While `cs_n` is high, `sdo_oe` and `busy_oe` are 0 (the outputs are high-impedance). Raising `cs_n` aborts the frame at once. The next frame then behaves normally.
- R11: PD1:PD0 = 11 keeps the block powered. PD1:PD0 = 00 powers it only from the start bit until the last decision. The codes 01 and 10 leave the stored policy unchanged. The policy is 00 after reset. `shdn_n` low forces `powered` low at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Serial clock; also paces the conversion |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select; high aborts the frame |
| sdi | input | 1 | Serial command input, sampled on rising edges |
| shdn_n | input | 1 | Active-low forced shutdown |
| cmp_hi | input | 1 | Comparator decision for the current trial code |
| sdo | output | 1 | Serial result output, updated on falling edges |
| sdo_oe | output | 1 | Output enable for `sdo` |
| busy | output | 1 | One-clock pulse before the first result bit |
| busy_oe | output | 1 | Output enable for `busy` |
| acquire | output | 1 | Sampling switch closed (track) when high |
| dac_code | output | 12 | Trial code to the capacitor DAC |
| pos_ch | output | 3 | Channel routed to the positive converter input |
| neg_ch | output | 3 | Channel routed to the negative input in differential mode |
| neg_common | output | 1 | Negative input taken from the common pin |
| powered | output | 1 | Analog section powered |

## Verification
All timing counts from the rising edge that takes the start bit. The host-side bench drives `sdi` just after each falling edge and samples every output just before the next rising edge.

Under that convention, the values can be read at these rising edges:
- `acquire` at edges 6 to 8.
- The multiplexer selects from edge 9 on.
- `busy` only at edge 9.
- Result bit 11 down to bit 0 at edges 10 to 21.
- Zero fill from edge 22.

Each check indexes the recorded cycle by frame edge plus the number of leading idle clocks. The same indexing is applied with an offset of 15 to the overlapped second command.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  // Width of the command word, start bit included.
  localparam int CMD_LEN = 8;

  // Position of each field, counted in rising edges after the start bit.
  // The order is fixed by the serial protocol.
  localparam int FLD_A2  = 1;
  localparam int FLD_A1  = 2;
  localparam int FLD_A0  = 3;
  localparam int FLD_SGL = 5;
  localparam int FLD_PD1 = 6;

  typedef enum logic [1:0] {
    FS_WAIT = 2'd0,
    FS_CMD  = 2'd1,
    FS_TAIL = 2'd2
  } frame_st_e;

  typedef struct packed {
    logic a2;
    logic a1;
    logic a0;
    logic sgl;
  } route_t;

endpackage

// File: rtl/adcseq_chsel.sv
module adcseq_chsel
  import adcseq_pkg::*;
(
  input  route_t     route,
  output logic [2:0] pos_ch,
  output logic [2:0] neg_ch,
  output logic       neg_common
);

  // The address bits are interleaved: A2 selects the odd member of a pair.
  // In differential mode the partner channel takes the negative side.
  always_comb begin
    pos_ch     = {route.a1, route.a0, route.a2};
    neg_ch     = {route.a1, route.a0, ~route.a2};
    neg_common = route.sgl;
  end

endmodule

// File: rtl/adcseq_frame.sv
module adcseq_frame
  import adcseq_pkg::*;
#(
  parameter int ACQ_LEN = 3,
  parameter int RESTART = 15
) (
  input  logic   sclk,
  input  logic   rst_n,
  input  logic   frm_rst_n,
  input  logic   sdi,
  output route_t route,
  output logic   pd1,
  output logic   acq,
  output logic   go,
  output logic   in_cmd
);

  localparam int CNT_W = $clog2(RESTART + 1);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(CMD_LEN - 1);
  localparam logic [CNT_W-1:0] ACQ_POS  = CNT_W'(CMD_LEN - ACQ_LEN);
  localparam logic [CNT_W-1:0] REARM    = CNT_W'(RESTART);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  frame_st_e        st;
  logic [CNT_W-1:0] pos;

  // Frame tracker. pos holds the number of the last rising edge since the start bit.
  always_ff @(posedge sclk or negedge frm_rst_n) begin
    if (!frm_rst_n) begin
      st  <= FS_WAIT;
      pos <= '0;
    end else begin
      case (st)
        FS_WAIT: begin
          if (sdi) begin
            st  <= FS_CMD;
            pos <= ONE;
          end
        end
        FS_CMD: begin
          pos <= pos + ONE;
          if (pos == LAST_POS) st <= FS_TAIL;
        end
        FS_TAIL: begin
          if (pos >= REARM) begin
            if (sdi) begin
              st  <= FS_CMD;
              pos <= ONE;
            end else begin
              st  <= FS_WAIT;
              pos <= '0;
            end
          end else begin
            pos <= pos + ONE;
          end
        end
        default: begin
          st  <= FS_WAIT;
          pos <= '0;
        end
      endcase
    end
  end

  // The routing fields survive a chip-select abort and are cleared only by reset.
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      route <= '0;
      pd1   <= 1'b0;
    end else if (st == FS_CMD) begin
      if (pos == CNT_W'(FLD_A2))  route.a2  <= sdi;
      if (pos == CNT_W'(FLD_A1))  route.a1  <= sdi;
      if (pos == CNT_W'(FLD_A0))  route.a0  <= sdi;
      if (pos == CNT_W'(FLD_SGL)) route.sgl <= sdi;
      if (pos == CNT_W'(FLD_PD1)) pd1       <= sdi;
    end
  end

  always_comb begin
    in_cmd = (st == FS_CMD);
    go     = in_cmd && (pos == LAST_POS);
    acq    = in_cmd && (pos >= ACQ_POS);
  end

endmodule

// File: rtl/adcseq_sar.sv
module adcseq_sar #(
  parameter int RES_W = 12
) (
  input  logic             sclk,
  input  logic             frm_rst_n,
  input  logic             go,
  input  logic             cmp_hi,
  output logic [RES_W-1:0] code,
  output logic             running,
  output logic             dec_bit,
  output logic             dec_first
);

  localparam logic [RES_W-1:0] MSB = {1'b1, {(RES_W-1){1'b0}}};

  // One-hot marker of the bit under test.
  logic [RES_W-1:0] mask;

  always_ff @(posedge sclk or negedge frm_rst_n) begin
    if (!frm_rst_n) begin
      code      <= '0;
      mask      <= '0;
      running   <= 1'b0;
      dec_bit   <= 1'b0;
      dec_first <= 1'b0;
    end else if (go) begin
      code      <= MSB;
      mask      <= MSB;
      running   <= 1'b1;
      dec_bit   <= 1'b0;
      dec_first <= 1'b1;
    end else if (running) begin
      code      <= (cmp_hi ? code : (code & ~mask)) | (mask >> 1);
      mask      <= mask >> 1;
      dec_bit   <= cmp_hi;
      dec_first <= 1'b0;
      if (mask[0]) running <= 1'b0;
    end else begin
      dec_bit   <= 1'b0;
      dec_first <= 1'b0;
    end
  end

endmodule

// File: rtl/adcseq_txout.sv
module adcseq_txout (
  input  logic sclk,
  input  logic frm_rst_n,
  input  logic cs_n,
  input  logic dec_bit,
  input  logic dec_first,
  output logic sdo,
  output logic sdo_oe,
  output logic busy,
  output logic busy_oe
);

  // Decisions made on a rising edge leave on the following falling edge.
  always_ff @(negedge sclk or negedge frm_rst_n) begin
    if (!frm_rst_n) begin
      sdo  <= 1'b0;
      busy <= 1'b0;
    end else begin
      sdo  <= dec_bit;
      busy <= dec_first;
    end
  end

  always_comb begin
    sdo_oe  = ~cs_n;
    busy_oe = ~cs_n;
  end

endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
  import adcseq_pkg::*;
#(
  parameter int RES_W   = 12,
  parameter int ACQ_LEN = 3,
  parameter int RESTART = RES_W + 3
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sdi,
  input  logic             shdn_n,
  input  logic             cmp_hi,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             busy,
  output logic             busy_oe,
  output logic             acquire,
  output logic [RES_W-1:0] dac_code,
  output logic [2:0]       pos_ch,
  output logic [2:0]       neg_ch,
  output logic             neg_common,
  output logic             powered
);

  logic   frm_rst_n;
  route_t route;
  logic   pd1;
  logic   go;
  logic   in_cmd;
  logic   running;
  logic   dec_bit;
  logic   dec_first;
  logic   pd_on;

  // Chip select high clears all frame state at once.
  assign frm_rst_n = rst_n & ~cs_n;

  adcseq_frame #(
    .ACQ_LEN (ACQ_LEN),
    .RESTART (RESTART)
  ) u_frame (
    .sclk      (sclk),
    .rst_n     (rst_n),
    .frm_rst_n (frm_rst_n),
    .sdi       (sdi),
    .route     (route),
    .pd1       (pd1),
    .acq       (acquire),
    .go        (go),
    .in_cmd    (in_cmd)
  );

  adcseq_chsel u_chsel (
    .route      (route),
    .pos_ch     (pos_ch),
    .neg_ch     (neg_ch),
    .neg_common (neg_common)
  );

  adcseq_sar #(
    .RES_W (RES_W)
  ) u_sar (
    .sclk      (sclk),
    .frm_rst_n (frm_rst_n),
    .go        (go),
    .cmp_hi    (cmp_hi),
    .code      (dac_code),
    .running   (running),
    .dec_bit   (dec_bit),
    .dec_first (dec_first)
  );

  adcseq_txout u_txout (
    .sclk      (sclk),
    .frm_rst_n (frm_rst_n),
    .cs_n      (cs_n),
    .dec_bit   (dec_bit),
    .dec_first (dec_first),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .busy      (busy),
    .busy_oe   (busy_oe)
  );

  // Power policy. PD0 arrives with the last command edge. Only the matching codes 00 and 11 take effect.
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)                  pd_on <= 1'b0;
    else if (go && (pd1 == sdi)) pd_on <= sdi;
  end

  assign powered = shdn_n & (pd_on | in_cmd | running);

endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker #(
  parameter int RES_W = 12
) (
  input logic             sclk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             shdn_n,
  input logic             busy,
  input logic             acquire,
  input logic [RES_W-1:0] dac_code,
  input logic             powered
);

  localparam logic [RES_W-1:0] MSB = {1'b1, {(RES_W-1){1'b0}}};

  // R3: the sampling window spans exactly three rising edges.
  a_r3_acq_window: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    $rose(acquire) |=> acquire ##1 acquire ##1 !acquire);

  // R4: busy follows the start of the hold.
  a_r4_busy_after_hold: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    $fell(acquire) |-> busy);

  // R4: busy lasts one clock only.
  a_r4_busy_single: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
    busy |=> !busy);

  // R6: the search starts from the mid-scale trial code.
  a_r6_trial_msb: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    busy |-> (dac_code == MSB));

  // R11: the analog section is powered during a conversion unless shut down.
  a_r11_busy_powered: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    (busy && shdn_n) |-> powered);

endmodule

bind adc_serial_seq adcseq_checker #(.RES_W(RES_W)) u_adcseq_chk (
  .sclk     (sclk),
  .rst_n    (rst_n),
  .cs_n     (cs_n),
  .shdn_n   (shdn_n),
  .busy     (busy),
  .acquire  (acquire),
  .dac_code (dac_code),
  .powered  (powered)
);

// File: tb/adc_serial_seq_bench.sv
module adc_serial_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NREC = 64;

  logic        sclk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  logic        shdn_n = 1'b1;
  logic        cmp_hi;
  logic        sdo, sdo_oe, busy, busy_oe, acquire, neg_common, powered;
  logic [11:0] dac_code;
  logic [2:0]  pos_ch, neg_ch;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [11:0] vin_tab [0:7];
  logic [11:0] held = '0;
  logic        stim  [0:NREC-1];
  logic        r_sdo [0:NREC-1];
  logic        r_busy[0:NREC-1];
  logic        r_acq [0:NREC-1];
  logic        r_pow [0:NREC-1];
  logic        r_com [0:NREC-1];
  logic [2:0]  r_pos [0:NREC-1];
  logic [2:0]  r_neg [0:NREC-1];

  always #(CLK_PERIOD/2) sclk = ~sclk;

  // Behavioural sample-and-hold plus comparator.
  always @(negedge acquire) held = vin_tab[pos_ch];
  assign cmp_hi = (held >= dac_code);

  adc_serial_seq u_adc_serial_seq (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .sdi(sdi), .shdn_n(shdn_n),
    .cmp_hi(cmp_hi), .sdo(sdo), .sdo_oe(sdo_oe), .busy(busy), .busy_oe(busy_oe),
    .acquire(acquire), .dac_code(dac_code), .pos_ch(pos_ch), .neg_ch(neg_ch),
    .neg_common(neg_common), .powered(powered)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] base_code(input int c, input int pass);
    int v;
    case (c)
      0: v = 0;     1: v = 4095;  2: v = 2048;  3: v = 2047;
      4: v = 1;     5: v = 1365;  6: v = 2730;  default: v = 3001;
    endcase
    return (pass == 0) ? 12'(v) : 12'(4095 - v);
  endfunction

  task automatic load_vin(input int pass);
    for (int c = 0; c < 8; c++) vin_tab[c] = base_code(c, pass);
  endtask

  task automatic clear_stim();
    for (int i = 0; i < NREC; i++) stim[i] = 1'b0;
  endtask

  task automatic put_cmd(input int at, input logic [7:0] cmd);
    for (int b = 0; b < 8; b++) stim[at + b] = cmd[7-b];
  endtask

  // Record i holds the outputs seen just before the rising edge that takes stim[i].
  task automatic play(input int n);
    for (int i = 1; i <= n; i++) begin
      @(negedge sclk);
      #1 sdi = stim[i];
      #(CLK_PERIOD/2 - 3);
      r_sdo[i] = sdo;  r_busy[i] = busy; r_acq[i] = acquire; r_pow[i] = powered;
      r_pos[i] = pos_ch; r_neg[i] = neg_ch; r_com[i] = neg_common;
    end
  endtask

  task automatic open_cs();
    @(negedge sclk);
    #1 cs_n = 1'b0; sdi = 1'b0;
  endtask

  task automatic close_cs();
    @(negedge sclk);
    #1 cs_n = 1'b1; sdi = 1'b0;
  endtask

  task automatic check_frame(input int off, input logic [7:0] cmd, input int n);
    int ep, en, res;
    bit sgl;
    sgl = cmd[2];
    ep  = 4 * cmd[5] + 2 * cmd[4] + cmd[6];
    en  = 4 * cmd[5] + 2 * cmd[4] + (1 - cmd[6]);
    chk(r_busy[off+8] == 1'b0, "R4 before", r_busy[off+8], 0);
    chk(r_busy[off+9] == 1'b1, "R4 pulse", r_busy[off+9], 1);
    chk(r_busy[off+10] == 1'b0, "R4 after", r_busy[off+10], 0);
    chk(r_acq[off+5] == 1'b0, "R3 pre", r_acq[off+5], 0);
    chk(r_acq[off+6] && r_acq[off+7] && r_acq[off+8], "R3 window", r_acq[off+7], 1);
    chk(r_acq[off+9] == 1'b0, "R3 hold", r_acq[off+9], 0);
    res = 0;
    for (int k = 0; k < 12; k++) res = res * 2 + int'(r_sdo[off+10+k]);
    chk(res == int'(vin_tab[ep]), "R1 R5 R6 result", res, int'(vin_tab[ep]));
    if (off + 22 <= n) chk(r_sdo[off+22] == 1'b0, "R5 zero fill", r_sdo[off+22], 0);
    chk(int'(r_pos[off+9]) == ep, "R2 R7 R8 pos", r_pos[off+9], ep);
    chk(r_com[off+9] == sgl, "R2 R7 R8 mode", r_com[off+9], sgl);
    if (!sgl) chk(int'(r_neg[off+9]) == en, "R8 neg", r_neg[off+9], en);
  endtask

  task automatic one_frame(input logic [7:0] cmd, input int lead, input int n);
    clear_stim();
    put_cmd(1 + lead, cmd);
    open_cs();
    play(n);
    check_frame(lead, cmd, n);
    close_cs();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    load_vin(0);
    clear_stim();
    repeat (3) @(negedge sclk);
    #1 rst_n = 1'b1;
    #2;
    // Reset state with chip select high.
    chk(sdo_oe == 1'b0, "R10 reset sdo_oe", sdo_oe, 0);
    chk(busy_oe == 1'b0, "R10 reset busy_oe", busy_oe, 0);
    chk(acquire == 1'b0, "R3 reset acquire", acquire, 0);
    chk(powered == 1'b0, "R11 reset policy", powered, 0);

    // Every address in both modes, with leading idle clocks, on two input sets.
    for (int pass = 0; pass < 2; pass++) begin
      load_vin(pass);
      for (int sg = 0; sg < 2; sg++) begin
        for (int a = 0; a < 8; a++) begin
          one_frame(8'h80 | 8'(a << 4) | 8'(sg << 2) | 8'h03, (a + pass) % 3, 28);
        end
      end
    end
    #2 chk(powered == 1'b1, "R11 always on", powered, 1);

    // Reserved power code leaves the policy.
    one_frame(8'hA5, 0, 24);
    #2 chk(powered == 1'b1, "R11 reserved", powered, 1);

    // Auto power-down.
    one_frame(8'hB4, 1, 26);
    chk(r_pow[13] == 1'b1, "R11 auto on", r_pow[13], 1);
    chk(r_pow[24] == 1'b0, "R11 auto off in frame", r_pow[24], 0);
    #2 chk(powered == 1'b0, "R11 auto idle", powered, 0);

    // Chip-select abort during acquisition.
    clear_stim();
    put_cmd(1, 8'hC4);
    open_cs();
    play(6);
    chk(r_acq[6] == 1'b1, "R3 abort pre", r_acq[6], 1);
    chk(sdo_oe == 1'b1, "R10 enabled", sdo_oe, 1);
    close_cs();
    #1;
    chk(sdo_oe == 1'b0 && busy_oe == 1'b0, "R10 disable", sdo_oe, 0);
    chk(acquire == 1'b0, "R10 abort acquire", acquire, 0);
    repeat (4) @(negedge sclk);
    #1 chk(busy == 1'b0 && powered == 1'b0, "R10 abort idle", busy, 0);
    one_frame(8'hE4, 0, 24);

    // High bits during the conversion tail are not starts.
    clear_stim();
    put_cmd(1, 8'h90);
    for (int i = 9; i <= 15; i++) stim[i] = 1'b1;
    open_cs();
    play(40);
    check_frame(0, 8'h90, 40);
    begin
      int nb;
      nb = 0;
      for (int i = 1; i <= 40; i++) nb += int'(r_busy[i]);
      chk(nb == 1, "R9 ignored tail", nb, 1);
    end
    close_cs();

    // Back-to-back commands every 15 clocks.
    clear_stim();
    put_cmd(1, 8'hD7);
    put_cmd(16, 8'h93);
    open_cs();
    play(40);
    check_frame(0, 8'hD7, 40);
    check_frame(15, 8'h93, 40);
    chk(r_busy[24] == 1'b1, "R9 overlap start", r_busy[24], 1);
    close_cs();

    // Forced shutdown.
    one_frame(8'hF7, 0, 24);
    #2 chk(powered == 1'b1, "R11 on before shutdown", powered, 1);
    shdn_n = 1'b0;
    #1 chk(powered == 1'b0, "R11 shutdown", powered, 0);
    shdn_n = 1'b1;
    #1 chk(powered == 1'b1, "R11 release", powered, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule